// File: doc/BRIEF.md
# Reset Sequencer with Vector Selection

This block generates the chip-wide reset of a microcontroller and decides which reset vector the processor fetches afterwards. It takes one-cycle request pulses from the low-voltage detector, the illegal-address detector, the watchdog and the clock monitor. It also watches the bidirectional open-drain reset pin. An asynchronous power-on reset puts it straight into a sequence. Any request starts a fixed sequence. First the block pulls the pin low for a fixed number of cycles. It then lets the pin go and waits a settling window. It then reads the synchronized pin level. During the whole sequence the active-high internal reset stays on, and it turns off on a clock edge.

The pin reading at the end of the settling window tells the causes apart. If the pin is still low, something outside is holding it down, or the cause was power or an external reset. In that case the common vector is selected and the internal reset waits for the pin to go high. If the pin reads high, the cause was internal. The pending watchdog and clock-monitor flags then pick the vector, and the clock monitor has priority. Both flags are cleared when the vector is latched.

The controller has four states:
- DRIVE: the pin is pulled low and the counter runs.
- SETTLE: the pin is released and the counter runs again.
- HOLD: the sample read low, and the block waits for the pin to rise.
- RUN: the internal reset is released.

It has these transitions:
- DRIVE→SETTLE when the drive count ends.
- SETTLE→RUN when the sample reads high.
- SETTLE→HOLD when the sample reads low.
- HOLD→RUN when the synchronized pin reads high.
- RUN→DRIVE when the synchronized pin reads low.
- Any state→DRIVE, with the counter cleared, on an internal request.

Top module: `rst_seq_top`

## Requirements
- R1: While `arst_n` is low, `sys_rst` and `pin_drive_low` are 1 and `vec_sel` is 00. After release, `sys_rst` stays 1 for DRIVE_CYC+SETTLE_CYC cycles, counting the reset cycle. With defaults this is 192 cycles, followed by a sample.
- R2: Every sequence starts with `pin_drive_low` high for exactly DRIVE_CYC (128) consecutive cycles. After that the pin is released, and it stays released for the rest of the sequence.
- R3: A sequence started by an internal request from RUN keeps `sys_rst` high for exactly 192 cycles when the sample reads high. It then drops on a clock edge, one cycle after the sample.
- R4: A low level on `pin_in` during RUN starts a sequence. It passes a two-flop synchronizer, so `sys_rst` rises on the third rising edge after the pin falls.
- R5: If the synchronized pin is still low at the sample, `sys_rst` stays high until the synchronized pin reads high. An external hold of L ≥ 192 cycles that starts the sequence gives exactly L cycles of `sys_rst`.
- R6: A low sample sets `vec_sel` = 00 (common vector), whatever the pending flags hold.
- R7: A high sample with a clock-monitor request pending sets `vec_sel` = 10, whatever the watchdog flag holds.
- R8: A high sample with only a watchdog request pending sets `vec_sel` = 01.
- R9: A high sample with no flag pending sets `vec_sel` = 00.
- R10: Both pending flags are cleared when the vector is latched. A following sequence with no new watchdog or clock-monitor request yields 00.
- R11: Any internal request during a sequence restarts it from DRIVE with the counter at zero. Flags set earlier in the sequence stay pending.
- R12: `vec_sel` changes only at the sample. It keeps its value through the next sequence until that sequence samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| lvr_req | input | 1 | Low-voltage reset request pulse |
| illaddr_req | input | 1 | Illegal-address reset request pulse |
| cop_req | input | 1 | Watchdog reset request pulse |
| clkmon_req | input | 1 | Clock-monitor reset request pulse |
| pin_in | input | 1 | Level read back from the reset pin, asynchronous |
| pin_drive_low | output | 1 | Enables the open-drain pull-down of the reset pin |
| sys_rst | output | 1 | Internal reset, active high |
| vec_sel | output | 2 | Vector select: 00 common, 01 watchdog, 10 clock monitor |

## Verification
The main sweep covers every combination of the watchdog and clock-monitor flags. Each combination is crossed with an external hold on the pin that ends well before the sample, just before it (190 cycles), just after it (191) and long after it. This separates the flag priority from the pin-low override and pins down the exact edge of the sample. Separate runs use pin-only resets of 1, 5, 192, 193 and 300 cycles, which tell the synchronizer latency and the fixed sequence length apart from the hold-extended length. Mid-sequence requests during DRIVE and during SETTLE show that the counter restarts while earlier flags survive. A flagless sequence after a watchdog sequence shows that the flags clear.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [1:0] {
        ST_DRIVE  = 2'd0,
        ST_SETTLE = 2'd1,
        ST_HOLD   = 2'd2,
        ST_RUN    = 2'd3
    } seq_state_t;

    localparam logic [1:0] VEC_COMMON  = 2'b00;
    localparam logic [1:0] VEC_WDOG    = 2'b01;
    localparam logic [1:0] VEC_CLKFAIL = 2'b10;

endpackage

// File: rtl/rst_pin_sync.sv
module rst_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) chain[0] <= 1'b1;
                else         chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) chain[i] <= 1'b1;
                else         chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
    import rst_seq_pkg::*;
#(
    parameter int DRIVE_CYC  = 128,
    parameter int SETTLE_CYC = 64
) (
    input  logic clk,
    input  logic arst_n,
    input  logic restart,
    input  logic pin_s,
    output logic drive_low,
    output logic sys_rst,
    output logic sample
);
    localparam int MAXC = (DRIVE_CYC > SETTLE_CYC) ? DRIVE_CYC : SETTLE_CYC;
    localparam int CW   = $clog2(MAXC) + 1;
    localparam logic [CW-1:0] DRIVE_LAST  = CW'(DRIVE_CYC - 1);
    localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);

    seq_state_t    st, nxt;
    logic [CW-1:0] cnt, nxt_cnt;

    always_comb begin
        nxt     = st;
        nxt_cnt = cnt;
        sample  = 1'b0;
        unique case (st)
            ST_DRIVE: begin
                if (cnt == DRIVE_LAST) begin
                    nxt     = ST_SETTLE;
                    nxt_cnt = '0;
                end else begin
                    nxt_cnt = cnt + 1'b1;
                end
            end
            ST_SETTLE: begin
                if (cnt == SETTLE_LAST) begin
                    sample  = 1'b1;
                    nxt     = pin_s ? ST_RUN : ST_HOLD;
                    nxt_cnt = '0;
                end else begin
                    nxt_cnt = cnt + 1'b1;
                end
            end
            ST_HOLD: begin
                if (pin_s) nxt = ST_RUN;
            end
            ST_RUN: begin
                if (!pin_s) begin
                    nxt     = ST_DRIVE;
                    nxt_cnt = '0;
                end
            end
            default: nxt = ST_DRIVE;
        endcase
        if (restart) begin
            nxt     = ST_DRIVE;
            nxt_cnt = '0;
            sample  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st  <= ST_DRIVE;
            cnt <= '0;
        end else begin
            st  <= nxt;
            cnt <= nxt_cnt;
        end
    end

    always_comb begin
        unique case (st)
            ST_DRIVE:  begin drive_low = 1'b1; sys_rst = 1'b1; end
            ST_SETTLE: begin drive_low = 1'b0; sys_rst = 1'b1; end
            ST_HOLD:   begin drive_low = 1'b0; sys_rst = 1'b1; end
            ST_RUN:    begin drive_low = 1'b0; sys_rst = 1'b0; end
            default:   begin drive_low = 1'b1; sys_rst = 1'b1; end
        endcase
    end

    // R2: the pin is only pulled down inside a sequence
    p_drive_in_rst_r2: assert property (@(posedge clk) disable iff (!arst_n)
        drive_low |-> sys_rst);

    // R3: the drive counter never runs past its limit
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!arst_n)
        (st == ST_DRIVE) |-> (cnt <= DRIVE_LAST));

    // R5: internal reset only drops after the synchronized pin read high
    p_fall_pin_high_r5: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(sys_rst) |-> $past(pin_s));

    // R4: a low pin in RUN starts the pull-down on the next cycle
    p_pin_start_r4: assert property (@(posedge clk) disable iff (!arst_n)
        (!sys_rst && !pin_s) |=> drive_low);

    // R11: a request restarts the sequence from zero
    p_restart_r11: assert property (@(posedge clk) disable iff (!arst_n)
        restart |=> (st == ST_DRIVE && cnt == '0));

endmodule

// File: rtl/rst_src_flags.sv
module rst_src_flags
    import rst_seq_pkg::*;
(
    input  logic       clk,
    input  logic       arst_n,
    input  logic       set_cop,
    input  logic       set_cm,
    input  logic       sample,
    input  logic       pin_s,
    output logic [1:0] vec_sel
);
    logic cop_pend, cm_pend;
    logic [1:0] vec_pick;

    always_comb begin
        if (!pin_s)       vec_pick = VEC_COMMON;
        else if (cm_pend) vec_pick = VEC_CLKFAIL;
        else if (cop_pend) vec_pick = VEC_WDOG;
        else              vec_pick = VEC_COMMON;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cop_pend <= 1'b0;
            cm_pend  <= 1'b0;
            vec_sel  <= VEC_COMMON;
        end else begin
            if (set_cop)     cop_pend <= 1'b1;
            else if (sample) cop_pend <= 1'b0;
            if (set_cm)      cm_pend  <= 1'b1;
            else if (sample) cm_pend  <= 1'b0;
            if (sample)      vec_sel  <= vec_pick;
        end
    end

    // R6: low sample gives the common vector
    p_low_common_r6: assert property (@(posedge clk) disable iff (!arst_n)
        (sample && !pin_s) |=> (vec_sel == VEC_COMMON));

    // R7: clock monitor wins on a high sample
    p_cm_prio_r7: assert property (@(posedge clk) disable iff (!arst_n)
        (sample && pin_s && cm_pend) |=> (vec_sel == VEC_CLKFAIL));

    // R8: watchdog alone on a high sample
    p_cop_only_r8: assert property (@(posedge clk) disable iff (!arst_n)
        (sample && pin_s && !cm_pend && cop_pend) |=> (vec_sel == VEC_WDOG));

    // R9: no flag on a high sample
    p_none_r9: assert property (@(posedge clk) disable iff (!arst_n)
        (sample && pin_s && !cm_pend && !cop_pend) |=> (vec_sel == VEC_COMMON));

    // R10: flags cleared once the vector is latched
    p_clear_r10: assert property (@(posedge clk) disable iff (!arst_n)
        (sample && !set_cop && !set_cm) |=> (!cop_pend && !cm_pend));

    // R12: vector only moves at a sample
    p_stable_r12: assert property (@(posedge clk) disable iff (!arst_n)
        !sample |=> $stable(vec_sel));

endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top #(
    parameter int DRIVE_CYC   = 128,
    parameter int SETTLE_CYC  = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       arst_n,
    input  logic       lvr_req,
    input  logic       illaddr_req,
    input  logic       cop_req,
    input  logic       clkmon_req,
    input  logic       pin_in,
    output logic       pin_drive_low,
    output logic       sys_rst,
    output logic [1:0] vec_sel
);
    logic pin_s;
    logic restart;
    logic sample;

    assign restart = lvr_req | illaddr_req | cop_req | clkmon_req;

    rst_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .d      (pin_in),
        .q      (pin_s)
    );

    rst_seq_fsm #(.DRIVE_CYC(DRIVE_CYC), .SETTLE_CYC(SETTLE_CYC)) u_fsm (
        .clk       (clk),
        .arst_n    (arst_n),
        .restart   (restart),
        .pin_s     (pin_s),
        .drive_low (pin_drive_low),
        .sys_rst   (sys_rst),
        .sample    (sample)
    );

    rst_src_flags u_flags (
        .clk     (clk),
        .arst_n  (arst_n),
        .set_cop (cop_req),
        .set_cm  (clkmon_req),
        .sample  (sample),
        .pin_s   (pin_s),
        .vec_sel (vec_sel)
    );

    // R1: while in power-on reset the sequence outputs hold
    always_comb begin
        if (!arst_n) begin
            a_por_state_r1: assert (sys_rst && pin_drive_low);
        end
    end

endmodule

// File: tb/tb_rst_seq_top.sv
module tb_rst_seq_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic arst_n;
    logic lvr_req, illaddr_req, cop_req, clkmon_req;
    logic ext_low;
    logic pin_in;
    logic pin_drive_low, sys_rst;
    logic [1:0] vec_sel;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign pin_in = !(pin_drive_low || ext_low);

    rst_seq_top dut (
        .clk(clk), .arst_n(arst_n), .lvr_req(lvr_req), .illaddr_req(illaddr_req),
        .cop_req(cop_req), .clkmon_req(clkmon_req), .pin_in(pin_in),
        .pin_drive_low(pin_drive_low), .sys_rst(sys_rst), .vec_sel(vec_sel)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_case(input int cop_at, input int cm_at, input int lvr_at,
                            input int ext_len, output int rstc, output int drvc,
                            output logic [1:0] vmid);
        rstc = 0;
        drvc = 0;
        vmid = vec_sel;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (k > 0) begin
                if (sys_rst) rstc++;
                if (pin_drive_low) drvc++;
                if (k == 100) vmid = vec_sel;
                if (!sys_rst && k > 5) break;
            end
            cop_req     = (k == cop_at);
            clkmon_req  = (k == cm_at);
            lvr_req     = (k == lvr_at);
            illaddr_req = 1'b0;
            ext_low     = (k < ext_len);
        end
        cop_req = 0; clkmon_req = 0; lvr_req = 0; ext_low = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int rc, dc, exp_rst, exp_vec, prev_vec;
        logic [1:0] vm;
        int lens [5] = '{0, 150, 190, 191, 300};
        int elen [5] = '{1, 5, 192, 193, 300};
        string tag;

        arst_n = 0; lvr_req = 0; illaddr_req = 0; cop_req = 0; clkmon_req = 0; ext_low = 0;
        repeat (3) @(negedge clk);
        check("R1 sys_rst in reset", int'(sys_rst), 1);
        check("R1 drive in reset", int'(pin_drive_low), 1);
        check("R1 vec in reset", int'(vec_sel), 0);
        arst_n = 1;
        rc = 0; dc = 0;
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            if (!sys_rst) break;
            rc++;
            if (pin_drive_low) dc++;
        end
        check("R1 por length", rc, 191);
        check("R2 por drive", dc, 127);
        check("R9 por vector", int'(vec_sel), 0);
        prev_vec = int'(vec_sel);

        // R10: watchdog sequence then a flagless one
        run_case(0, -1, -1, 0, rc, dc, vm);
        check("R8 cop vector", int'(vec_sel), 1);
        run_case(-1, -1, 0, 0, rc, dc, vm);
        check("R12 vec held mid sequence", int'(vm), 1);
        check("R10 flags cleared", int'(vec_sel), 0);
        prev_vec = 0;

        // flag x hold sweep
        for (int cm = 0; cm < 2; cm++) begin
            for (int cop = 0; cop < 2; cop++) begin
                for (int li = 0; li < 5; li++) begin
                    run_case(cop ? 0 : -1, cm ? 0 : -1, 0, lens[li], rc, dc, vm);
                    exp_rst = (lens[li] + 2 > 192) ? lens[li] + 2 : 192;
                    if (lens[li] > 190)  begin exp_vec = 0; tag = "R6"; end
                    else if (cm != 0)    begin exp_vec = 2; tag = "R7"; end
                    else if (cop != 0)   begin exp_vec = 1; tag = "R8"; end
                    else                 begin exp_vec = 0; tag = "R9"; end
                    check(exp_rst > 192 ? "R5 held length" : "R3 length", rc, exp_rst);
                    check("R2 drive length", dc, 128);
                    check({tag, " vector"}, int'(vec_sel), exp_vec);
                    check("R12 vec held", int'(vm), prev_vec);
                    prev_vec = int'(vec_sel);
                end
            end
        end

        // pin-only resets
        for (int ei = 0; ei < 5; ei++) begin
            run_case(-1, -1, -1, elen[ei], rc, dc, vm);
            exp_rst = (elen[ei] > 192) ? elen[ei] : 192;
            check(elen[ei] > 192 ? "R5 ext held length" : "R4 ext length", rc, exp_rst);
            check("R4 ext drive", dc, 128);
            check("R6 ext vector", int'(vec_sel), 0);
        end

        // restarts
        run_case(0, 50, -1, 0, rc, dc, vm);
        check("R11 restart in drive length", rc, 242);
        check("R11 restart in drive drive", dc, 178);
        check("R11 restart keeps cop, cm wins", int'(vec_sel), 2);
        run_case(0, -1, 150, 0, rc, dc, vm);
        check("R11 restart in settle length", rc, 342);
        check("R11 restart in settle drive", dc, 256);
        check("R11 restart keeps cop", int'(vec_sel), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule